// File: doc/BRIEF.md
# Boot Remap and Abort Controller

This block sits between a processor bus and its memories and decides which memory answers each access. While reset is held low it watches a boot-mode pin. When reset is released it fixes the choice of boot memory, which then appears at the bottom of the address space where the exception vectors live. A low pin selects external chip select 0. A pin that stayed high selects the internal emulation SRAM bank.

Software has two single-register controls. A remap command swaps the low region over to the internal primary SRAM. It also opens up external chip selects 1 and up. Only a reset can undo it. A mode register sets or clears write protection on the emulation SRAM bank. Every bus access is decoded in the same cycle into at most one select output. An access to an address that nothing decodes, or a write that the protection blocks, raises the abort output and reaches no memory.

Top module: `brc_top`

## Requirements
- R1: The boot memory is the emulation SRAM only if `boot_pin` was high on each of the last 10 clock edges at which `rst_n` was low. A pin that is high on 9 of those edges, or on more edges that stop short of the last one, does not qualify.
- R2: A single low sample inside that 10-edge window selects external chip select 0 (`sel_ext[0]`) as boot memory. Once `rst_n` is high, changes on `boot_pin` have no effect on the decode.
- R3: Before remap, addresses 0x0000_0000 to 0x000F_FFFF reach the boot memory. Chip select k (k = 0..7) decodes 0x0100_0000 + k·0x0100_0000 with a 16 MiB window each, and an access to k ≥ 1 aborts.
- R4: A configuration write to register 0 (`cfg_sel`=0) with `cfg_wdata` bit 0 set performs remap from the next cycle on. The low region then reaches the primary SRAM (`sel_pri`) and chip selects 1..7 become accessible. The same write with bit 0 clear has no effect.
- R5: Remap is sticky. No configuration write clears it, and only `rst_n` low does.
- R6: After reset the emulation SRAM (base 0x0040_0000, 1 MiB, and the low region when it is the boot memory) is write-protected. A write there aborts and drives no select, while reads are served.
- R7: Writing exactly 0x01 to register 1 (`cfg_sel`=1) removes the protection. Writing exactly 0x00 restores it. Any other value leaves it unchanged.
- R8: An access to any address outside the low region, the primary SRAM, the emulation SRAM and the chip select windows aborts and drives no select.
- R9: Select and abort outputs are combinational on the current access. With `bus_valid` low they are all zero. At most one of them is high at any time.
- R10: The primary SRAM (base 0x0030_0000, 1 MiB) is reachable for reads and writes both before and after remap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; boot pin sampled while low |
| boot_pin | input | 1 | Boot-mode selection pin |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 remap command, 1 protection mode |
| cfg_wdata | input | DW (8) | Configuration write data |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | Access is a write |
| bus_addr | input | AW (32) | Access address |
| sel_ext | output | NUM_CS (8) | External chip select outputs |
| sel_pri | output | 1 | Primary SRAM select |
| sel_emu | output | 1 | Emulation SRAM select |
| bus_abort | output | 1 | Abort for undefined or blocked access |

## Verification
The bench sets up the boot window edges: exactly 10 high samples at the end, 9 high samples at the end, and one low sample in the middle. If the design counted the wrong number of samples, or did not latch the result, boot would land on the other memory at address zero. It writes 0 to the remap bit and then tries to clear remap after setting it. A design that remapped on any write, or that let software undo remap, would map the wrong memory at address zero or wrongly allow chip selects 1 to 7. Write protection is tested on both aliases of the emulation bank and with a mode value other than 0 or 1. A wrong decode there would either let a blocked write reach the select outputs or fail to raise the abort.

// File: rtl/brc_pkg.sv
package brc_pkg;
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_EXT  = 2'd1,
      TGT_PRI  = 2'd2,
      TGT_EMU  = 2'd3
   } tgt_e;

   localparam logic REG_REMAP = 1'b0;
   localparam logic REG_MODE  = 1'b1;
endpackage

// File: rtl/brc_boot_sampler.sv
module brc_boot_sampler #(
   parameter int QUAL = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic boot_hi_o
);
   if (QUAL < 2) begin : g_bad_qual
      $error("brc_boot_sampler: QUAL must be at least 2");
   end

   logic [QUAL-2:0] hist_q;
   logic [QUAL-1:0] window;
   logic            boot_q;

   assign window = {hist_q, pin};

   // runs only while reset is held; result frozen at release
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= window[QUAL-2:0];
         boot_q <= &window;
      end
   end

   assign boot_hi_o = boot_q;

   assert_boot_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(boot_hi_o));
endmodule

// File: rtl/brc_cfg_regs.sv
module brc_cfg_regs
   import brc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          sel,
   input  logic [DW-1:0] wdata,
   output logic          remap_o,
   output logic          prot_o
);
   if (DW < 1) begin : g_bad_dw
      $error("brc_cfg_regs: DW must be at least 1");
   end

   localparam logic [DW-1:0] MODE_OPEN = DW'(1);
   localparam logic [DW-1:0] MODE_LOCK = '0;

   logic remap_q, prot_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remap_q <= 1'b0;
         prot_q  <= 1'b1;
      end else if (we) begin
         if (sel == REG_REMAP) begin
            if (wdata[0]) remap_q <= 1'b1;
         end else begin
            if (wdata == MODE_OPEN)      prot_q <= 1'b0;
            else if (wdata == MODE_LOCK) prot_q <= 1'b1;
         end
      end
   end

   assign remap_o = remap_q;
   assign prot_o  = prot_q;

   assert_remap_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(remap_o)) |-> remap_o);
   assert_mode_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == REG_MODE && wdata == MODE_OPEN) |=> !prot_o);
   assert_mode_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == REG_MODE && wdata == MODE_LOCK) |=> prot_o);
endmodule

// File: rtl/brc_addr_decode.sv
module brc_addr_decode
   import brc_pkg::*;
#(
   parameter int              AW       = 32,
   parameter int              NUM_CS   = 8,
   parameter int              LOW_LOG2 = 20,
   parameter int              RAM_LOG2 = 20,
   parameter int              CS_LOG2  = 24,
   parameter logic [AW-1:0]   PRI_BASE = 32'h0030_0000,
   parameter logic [AW-1:0]   EMU_BASE = 32'h0040_0000,
   parameter logic [AW-1:0]   EXT_BASE = 32'h0100_0000
) (
   input  logic              valid,
   input  logic              write,
   input  logic [AW-1:0]     addr,
   input  logic              remap,
   input  logic              boot_hi,
   input  logic              prot,
   output logic [NUM_CS-1:0] sel_ext,
   output logic              sel_pri,
   output logic              sel_emu,
   output logic              abort
);
   localparam int LTW = AW - LOW_LOG2;
   localparam int RTW = AW - RAM_LOG2;
   localparam int CTW = AW - CS_LOG2;

   if (NUM_CS < 1 || NUM_CS > 8) begin : g_bad_cs
      $error("brc_addr_decode: NUM_CS out of range");
   end
   if (LOW_LOG2 > RAM_LOG2 || RAM_LOG2 > CS_LOG2 || CS_LOG2 >= AW) begin : g_bad_win
      $error("brc_addr_decode: window sizes must nest");
   end

   logic              low_hit, pri_hit, emu_hit;
   logic [NUM_CS-1:0] cs_hit;
   tgt_e              tgt;
   logic [NUM_CS-1:0] ext_vec;
   logic              blocked, go;

   assign low_hit = (addr[AW-1:LOW_LOG2] == LTW'(0));
   assign pri_hit = (addr[AW-1:RAM_LOG2] == PRI_BASE[AW-1:RAM_LOG2]);
   assign emu_hit = (addr[AW-1:RAM_LOG2] == EMU_BASE[AW-1:RAM_LOG2]);

   for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
      localparam logic [CTW-1:0] TAG = EXT_BASE[AW-1:CS_LOG2] + CTW'(k);
      assign cs_hit[k] = (addr[AW-1:CS_LOG2] == TAG);
   end

   always_comb begin
      tgt     = TGT_NONE;
      ext_vec = '0;
      if (low_hit) begin
         if (remap)        tgt = TGT_PRI;
         else if (boot_hi) tgt = TGT_EMU;
         else begin
            tgt        = TGT_EXT;
            ext_vec[0] = 1'b1;
         end
      end else if (pri_hit) begin
         tgt = TGT_PRI;
      end else if (emu_hit) begin
         tgt = TGT_EMU;
      end else if (|cs_hit) begin
         if (cs_hit[0] || remap) begin
            tgt     = TGT_EXT;
            ext_vec = cs_hit;
         end
      end
   end

   assign blocked = (tgt == TGT_EMU) && write && prot;
   assign abort   = valid && ((tgt == TGT_NONE) || blocked);
   assign go      = valid && !abort;
   assign sel_ext = (go && tgt == TGT_EXT) ? ext_vec : '0;
   assign sel_pri = go && (tgt == TGT_PRI);
   assign sel_emu = go && (tgt == TGT_EMU);
endmodule

// File: rtl/brc_top.sv
module brc_top #(
   parameter int            AW       = 32,
   parameter int            DW       = 8,
   parameter int            NUM_CS   = 8,
   parameter int            QUAL     = 10,
   parameter int            LOW_LOG2 = 20,
   parameter int            RAM_LOG2 = 20,
   parameter int            CS_LOG2  = 24,
   parameter logic [AW-1:0] PRI_BASE = 32'h0030_0000,
   parameter logic [AW-1:0] EMU_BASE = 32'h0040_0000,
   parameter logic [AW-1:0] EXT_BASE = 32'h0100_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_pin,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [DW-1:0]     cfg_wdata,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [AW-1:0]     bus_addr,
   output logic [NUM_CS-1:0] sel_ext,
   output logic              sel_pri,
   output logic              sel_emu,
   output logic              bus_abort
);
   logic boot_hi, remap, prot;

   brc_boot_sampler #(.QUAL(QUAL)) u_boot (
      .clk(clk), .rst_n(rst_n), .pin(boot_pin), .boot_hi_o(boot_hi));

   brc_cfg_regs #(.DW(DW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
      .wdata(cfg_wdata), .remap_o(remap), .prot_o(prot));

   brc_addr_decode #(
      .AW(AW), .NUM_CS(NUM_CS), .LOW_LOG2(LOW_LOG2), .RAM_LOG2(RAM_LOG2),
      .CS_LOG2(CS_LOG2), .PRI_BASE(PRI_BASE), .EMU_BASE(EMU_BASE),
      .EXT_BASE(EXT_BASE)
   ) u_dec (
      .valid(bus_valid), .write(bus_write), .addr(bus_addr),
      .remap(remap), .boot_hi(boot_hi), .prot(prot),
      .sel_ext(sel_ext), .sel_pri(sel_pri), .sel_emu(sel_emu),
      .abort(bus_abort));

   assert_one_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_ext, sel_pri, sel_emu, bus_abort}));
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |-> (!bus_abort && sel_ext == '0 && !sel_pri && !sel_emu));
   assert_blocked_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && prot) |-> !sel_emu);
   assert_remap_opens_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (remap && bus_valid && bus_addr[AW-1:LOW_LOG2] == '0) |-> sel_pri);

   if (NUM_CS > 1) begin : g_gate_chk
      assert_cs_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !remap |-> (sel_ext[NUM_CS-1:1] == '0));
   end
endmodule

// File: tb/tb_brc_top.sv
`timescale 1ns/1ps
module tb_brc_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_pin = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [7:0]  sel_ext;
   logic        sel_pri, sel_emu, bus_abort;

   int    n_run = 0;
   int    n_fail = 0;
   bit    done = 0;
   string cur_req = "R9";

   // reference model state
   logic  hist[$];
   bit    m_boot = 0, m_remap = 0, m_prot = 1;

   always #2 clk = ~clk;

   brc_top dut (
      .clk(clk), .rst_n(rst_n), .boot_pin(boot_pin), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .bus_valid(bus_valid),
      .bus_write(bus_write), .bus_addr(bus_addr), .sel_ext(sel_ext),
      .sel_pri(sel_pri), .sel_emu(sel_emu), .bus_abort(bus_abort));

   always @(posedge clk) begin
      if (!rst_n) begin
         hist.push_back(boot_pin);
         m_boot = 0;
         if (hist.size() >= 10) begin
            m_boot = 1;
            for (int i = hist.size() - 10; i < hist.size(); i++)
               if (hist[i] !== 1'b1) m_boot = 0;
         end
         m_remap = 0;
         m_prot  = 1;
      end else if (cfg_we) begin
         if (cfg_sel == 1'b0) begin
            if (cfg_wdata[0]) m_remap = 1;
         end else if (cfg_wdata == 8'h01) m_prot = 0;
         else if (cfg_wdata == 8'h00) m_prot = 1;
      end
   end

   function automatic logic [10:0] model_out();
      logic [10:0] r;
      int unsigned a, k;
      int tgt; // 0 none 1 ext 2 pri 3 emu
      r = '0;
      k = 0;
      tgt = 0;
      a = bus_addr;
      if (!bus_valid) return r;
      if (a < 32'h0010_0000) begin
         if (m_remap) tgt = 2;
         else if (m_boot) tgt = 3;
         else begin tgt = 1; k = 0; end
      end else if (a >= 32'h0030_0000 && a < 32'h0040_0000) tgt = 2;
      else if (a >= 32'h0040_0000 && a < 32'h0050_0000) tgt = 3;
      else if (a >= 32'h0100_0000 && a < 32'h0900_0000) begin
         k = (a - 32'h0100_0000) >> 24;
         if (k == 0 || m_remap) tgt = 1;
      end
      if (tgt == 0 || (tgt == 3 && bus_write && m_prot)) r[10] = 1'b1;
      else if (tgt == 3) r[9] = 1'b1;
      else if (tgt == 2) r[8] = 1'b1;
      else r[k] = 1'b1;
      return r;
   endfunction

   // compare against the model every cycle, away from the edge
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         logic [10:0] got, exp;
         got = {bus_abort, sel_emu, sel_pri, sel_ext};
         exp = model_out();
         n_run++;
         if (got !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h wr=%b got=%b exp=%b", cur_req, bus_addr,
                     bus_write, got, exp);
         end
      end
   end

   task automatic do_reset(input int n, input logic [31:0] pat);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk);
         rst_n = 1'b0; bus_valid = 1'b0; cfg_we = 1'b0;
         boot_pin = pat[i];
      end
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic acc(input logic [31:0] a, input logic wr);
      @(negedge clk);
      cfg_we = 1'b0; bus_valid = 1'b1; bus_write = wr; bus_addr = a;
   endtask

   task automatic cfg(input logic s, input logic [7:0] d);
      @(negedge clk);
      bus_valid = 1'b0; cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
   endtask

   task automatic idle();
      @(negedge clk);
      bus_valid = 1'b0; cfg_we = 1'b0;
   endtask

   initial begin
      // R1: all-high window boots from emulation SRAM
      cur_req = "R1";
      do_reset(12, 32'h0000_0FFF);
      cur_req = "R9"; idle(); idle();
      cur_req = "R1"; acc(32'h0000_0000, 0); acc(32'h0000_0020, 0);
      cur_req = "R6"; acc(32'h0000_0004, 1); acc(32'h0040_0100, 1);
      acc(32'h0040_0100, 0);
      cur_req = "R3"; acc(32'h0200_0000, 0); acc(32'h0800_0010, 1);
      acc(32'h0100_0010, 1);
      cur_req = "R10"; acc(32'h0030_0040, 1); acc(32'h003F_FFFC, 0);
      cur_req = "R8"; acc(32'h2000_0000, 0); acc(32'h0020_0000, 1);
      acc(32'h0900_0000, 0); acc(32'h0050_0000, 0);
      cur_req = "R2"; @(negedge clk); boot_pin = 1'b0; acc(32'h0000_0000, 0);

      // R1: exactly the last 10 samples high
      cur_req = "R1";
      do_reset(20, 32'h0000_03FF);
      acc(32'h0000_0010, 0);
      // R1: only 9 samples high -> external boot
      do_reset(20, 32'h0000_01FF);
      acc(32'h0000_0010, 0);
      // R1: high run ends one sample early
      do_reset(20, 32'h0000_07FE);
      acc(32'h0000_0010, 0);

      // R2: one low sample in the middle of the window
      cur_req = "R2";
      do_reset(16, 32'h0000_FFEF);
      acc(32'h0000_0000, 0); acc(32'h0000_0000, 1);
      @(negedge clk); boot_pin = 1'b1;
      acc(32'h0000_0008, 0);
      cur_req = "R3"; acc(32'h0300_0000, 0); acc(32'h0100_0000, 0);

      // R4: remap write with bit 0 clear is ignored
      cur_req = "R4";
      cfg(1'b0, 8'hFE); acc(32'h0000_0000, 0); acc(32'h0500_0000, 0);
      cfg(1'b0, 8'h01); acc(32'h0000_0000, 1); acc(32'h0500_0000, 0);
      acc(32'h0800_0004, 1); acc(32'h0100_0000, 0);
      cur_req = "R10"; acc(32'h0030_0000, 0);
      // R5: remap cannot be undone by software
      cur_req = "R5";
      cfg(1'b0, 8'h00); acc(32'h0000_0000, 0);
      cfg(1'b1, 8'h00); acc(32'h0000_0000, 0); acc(32'h0200_0000, 0);
      do_reset(12, 32'h0000_0000);
      acc(32'h0000_0000, 0); acc(32'h0200_0000, 0);

      // R7: unprotect, odd value, reprotect
      cur_req = "R7";
      do_reset(12, 32'h0000_0FFF);
      acc(32'h0000_0000, 1);
      cfg(1'b1, 8'h01); acc(32'h0000_0000, 1); acc(32'h0040_0200, 1);
      cfg(1'b1, 8'h03); acc(32'h0040_0200, 1);
      cfg(1'b1, 8'h00); acc(32'h0040_0200, 1); acc(32'h0040_0200, 0);
      cfg(1'b1, 8'h81); acc(32'h0040_0200, 1);
      cur_req = "R6";
      cfg(1'b0, 8'h01); acc(32'h0000_0000, 1); acc(32'h0040_0000, 1);
      cur_req = "R9"; idle(); idle();

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule